// File: doc/BRIEF.md
# PCM Sound Chip Register Write Sequencer

This block sits on the host side of a multi-channel PCM sound generator and turns one register-write request into the bus cycles the chip expects. A request carries a logical voice number (0 to 27), a register number and a data byte. The chip numbers its voices in a 32-slot space in which the last slot of every group of eight is unused. The sequencer converts the logical voice to its physical slot and then drives three writes to three port addresses: slot select, register select, data.

Before the first write the sequencer reads the chip's data address and waits until bit 0 of that byte, the busy flag, is clear. The writes are separated by a configurable number of idle cycles, and each write strobe lasts a configurable number of cycles. Two shortened forms exist: a slot-select-only write, and a register-plus-data write that keeps the slot selected by an earlier request. A request whose voice number is out of range raises an error pulse and drives no bus cycle. Requests use a valid/ready handshake, and ready stays low until the last strobe of the accepted request has finished.

Top module: `pcm_regwr_seq`

## Requirements
- R1: After reset, req_ready is 1, bus_cs_n, bus_rd_n and bus_wr_n are 1, and req_err is 0.
- R2: During the slot-select strobe, bus_dout carries physical slot = 8*floor(v/7) + (v mod 7) for logical voice v, zero-extended. Slots 7, 15, 23 and 31 never appear.
- R3: Port addresses are fixed: slot select at bus_addr 1, register select at bus_addr 2, data at bus_addr 0. A write strobe holds bus_cs_n and bus_wr_n low together, with bus_dout carrying the byte for that address.
- R4: A full request writes slot select, then register number, then data byte, in that order.
- R5: Each write strobe lasts exactly STROBE_CYC cycles. Between two strobes of one request there are exactly GAP_CYC cycles with bus_cs_n high.
- R6: After a request is accepted, the sequencer drives a read (bus_cs_n and bus_rd_n low, bus_addr 0) on every cycle until bus_rdbit is sampled 0 at a clock edge. The first write strobe starts in the following cycle.
- R7: req_op selects the form: 2'b00 and 2'b11 give the full three-write sequence, 2'b01 gives the slot-select write only, and 2'b10 gives register and data writes only. For 2'b10 req_chan is ignored and never raises an error.
- R8: A request with req_op other than 2'b10 and req_chan of 28 or more is taken while ready is high. req_err is 1 for the cycle after acceptance, and no bus cycle is issued for it.
- R9: req_ready is 0 from the cycle after a request is accepted through the last cycle of its final strobe, and returns to 1 in the next cycle.
- R10: bus_rd_n and bus_wr_n are never low together, and bus_wr_n is low only while bus_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | Request form (full, slot only, register and data only) |
| req_chan | input | 5 | Logical voice number |
| req_reg | input | 8 | Register number |
| req_data | input | 8 | Data byte |
| req_err | output | 1 | One-cycle pulse for a rejected voice number |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | 4 | Port address |
| bus_dout | output | 8 | Write data |
| bus_rdbit | input | 1 | Bit 0 of the byte read from the data address (busy) |

## Verification
Full writes are applied to all 28 voices, which exposes any slip in the group-of-seven slot remap at each group boundary. The busy hold-off varies from zero to three cycles, so an off-by-one in the poll exit shows up as a shifted strobe. The slot-only and register-plus-data forms are run with out-of-range voice numbers, which separates "channel ignored" from "channel rejected". Out-of-range full and slot-only requests confirm that the error pulse comes with a silent bus and that ready stays high.

// File: rtl/pcm_regwr_seq.sv
module pcm_regwr_seq #(
  parameter int NUM_CH     = 28,
  parameter int GROUP      = 7,
  parameter int GAP_CYC    = 2,
  parameter int STROBE_CYC = 2,
  parameter int CHW        = 5,
  parameter int DW         = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_op,
  input  logic [CHW-1:0] req_chan,
  input  logic [DW-1:0]  req_reg,
  input  logic [DW-1:0]  req_data,
  output logic           req_err,
  output logic           bus_cs_n,
  output logic           bus_rd_n,
  output logic           bus_wr_n,
  output logic [3:0]     bus_addr,
  output logic [DW-1:0]  bus_dout,
  input  logic           bus_rdbit
);
  localparam int CNT_MAX = (GAP_CYC > STROBE_CYC) ? GAP_CYC : STROBE_CYC;
  localparam int CNTW = $clog2(CNT_MAX + 1);
  localparam logic [1:0] OP_CHAN = 2'b01;
  localparam logic [1:0] OP_REGD = 2'b10;
  localparam logic [3:0] A_DATA = 4'd0;
  localparam logic [3:0] A_CHAN = 4'd1;
  localparam logic [3:0] A_REG  = 4'd2;

  typedef enum logic [1:0] {S_IDLE, S_POLL, S_STRB, S_GAP} st_t;

  st_t            state;
  logic [CNTW-1:0] cnt;
  logic [1:0]     step;
  logic [1:0]     op_q;
  logic [CHW-1:0] slot_q;
  logic [DW-1:0]  reg_q, data_q;

  wire needs_chan = (req_op != OP_REGD);
  wire chan_bad   = (req_chan >= CHW'(NUM_CH));
  wire [CHW-1:0] slot_w = req_chan + req_chan / CHW'(GROUP);
  wire last_step  = (step == 2'd2) || (step == 2'd0 && op_q == OP_CHAN);
  wire strb_end   = (cnt == CNTW'(STROBE_CYC - 1));
  wire gap_end    = (cnt == CNTW'(GAP_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      step   <= '0;
      op_q   <= '0;
      slot_q <= '0;
      reg_q  <= '0;
      data_q <= '0;
      req_err <= 1'b0;
    end else begin
      req_err <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid) begin
            if (needs_chan && chan_bad) begin
              req_err <= 1'b1;
            end else begin
              op_q   <= req_op;
              slot_q <= slot_w;
              reg_q  <= req_reg;
              data_q <= req_data;
              step   <= (req_op == OP_REGD) ? 2'd1 : 2'd0;
              state  <= S_POLL;
            end
          end
        S_POLL:
          if (!bus_rdbit) begin
            cnt   <= '0;
            state <= S_STRB;
          end
        S_STRB:
          if (strb_end) begin
            cnt   <= '0;
            state <= last_step ? S_IDLE : S_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_GAP:
          if (gap_end) begin
            cnt   <= '0;
            step  <= step + 2'd1;
            state <= S_STRB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign bus_cs_n  = !(state == S_POLL || state == S_STRB);
  assign bus_rd_n  = !(state == S_POLL);
  assign bus_wr_n  = !(state == S_STRB);

  always_comb begin
    bus_addr = A_DATA;
    bus_dout = '0;
    if (state != S_IDLE && state != S_POLL) begin
      case (step)
        2'd0: begin bus_addr = A_CHAN; bus_dout = DW'(slot_q); end
        2'd1: begin bus_addr = A_REG;  bus_dout = reg_q;       end
        default: begin bus_addr = A_DATA; bus_dout = data_q;   end
      endcase
    end
  end
endmodule

// File: rtl/pcm_regwr_seq_chk.sv
module pcm_regwr_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          req_err,
  input logic          bus_cs_n,
  input logic          bus_rd_n,
  input logic          bus_wr_n,
  input logic [3:0]    bus_addr,
  input logic [DW-1:0] bus_dout,
  input logic          bus_rdbit
);
  p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  p_wr_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_cs_n);
  p_err_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (bus_cs_n && req_ready));
  p_busy_on_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !req_ready);
  p_slot_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && bus_addr == 4'd1) |-> (bus_dout[2:0] != 3'b111 && bus_dout < DW'(32)));
  p_poll_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> bus_addr == 4'd0);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && bus_rdbit) |=> !bus_rd_n);
  p_poll_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && !bus_rdbit) |=> !bus_wr_n);
  p_strobe_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_addr) && $stable(bus_dout)));
endmodule

bind pcm_regwr_seq pcm_regwr_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_rdbit(bus_rdbit)
);

// File: tb/pcm_regwr_seq_bench.sv
module pcm_regwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 2;
  localparam int STB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'b00;
  logic [4:0] req_chan = '0;
  logic [7:0] req_reg = '0, req_data = '0;
  logic req_err, bus_cs_n, bus_rd_n, bus_wr_n, bus_rdbit = 1'b0;
  logic [3:0] bus_addr;
  logic [7:0] bus_dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_regwr_seq #(.GAP_CYC(GAP), .STROBE_CYC(STB)) u_pcm_regwr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chan(req_chan), .req_reg(req_reg), .req_data(req_data),
    .req_err(req_err), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_rdbit(bus_rdbit));

  typedef struct {
    bit cs_n; bit rd_n; bit wr_n; bit [3:0] addr; bit [7:0] dout;
    bit ready; bit err; string tag;
  } exp_t;

  exp_t exp_q[$];
  int vectors = 0;
  int misses = 0;
  bit checking = 0;
  bit done = 0;

  function automatic exp_t idle_e(bit err, string tag);
    exp_t e;
    e.cs_n = 1; e.rd_n = 1; e.wr_n = 1; e.addr = 0; e.dout = 0;
    e.ready = 1; e.err = err; e.tag = tag;
    return e;
  endfunction

  task automatic miss(string tag, string what, int act, int expv);
    misses++;
    $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
  endtask

  always @(negedge clk) begin
    if (checking) begin
      exp_t e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : idle_e(0, "R9");
      vectors++;
      if (bus_cs_n !== e.cs_n) miss(e.tag, "cs_n", bus_cs_n, e.cs_n);
      if (bus_rd_n !== e.rd_n) miss(e.tag, "rd_n", bus_rd_n, e.rd_n);
      if (bus_wr_n !== e.wr_n) miss(e.tag, "wr_n", bus_wr_n, e.wr_n);
      if (!e.cs_n && bus_addr !== e.addr) miss(e.tag, "addr", bus_addr, e.addr);
      if (!e.wr_n && bus_dout !== e.dout) miss(e.tag, "dout", bus_dout, e.dout);
      if (req_ready !== e.ready) miss("R9", "ready", req_ready, e.ready);
      if (req_err !== e.err) miss("R8", "err", req_err, e.err);
    end
  end

  // R2: independent slot formula
  function automatic bit [7:0] slot_of(int v);
    return 8'((v / 7) * 8 + (v % 7));
  endfunction

  task automatic do_req(bit [1:0] op, int ch, bit [7:0] rg, bit [7:0] dt, int busy_n);
    bit bad;
    int first, last;
    @(negedge clk); #1;
    req_valid = 1; req_op = op; req_chan = 5'(ch); req_reg = rg; req_data = dt;
    bus_rdbit = (busy_n > 0);
    bad = (op != 2'b10) && (ch >= 28);
    if (bad) begin
      exp_q.push_back(idle_e(1, "R8"));
      @(posedge clk); #1;
      req_valid = 0;
    end else begin
      first = (op == 2'b10) ? 1 : 0;
      last  = (op == 2'b01) ? 0 : 2;
      for (int i = 0; i <= busy_n; i++) begin
        exp_t e;
        e = idle_e(0, "R6"); e.cs_n = 0; e.rd_n = 0; e.addr = 0; e.ready = 0;
        exp_q.push_back(e);
      end
      for (int s = first; s <= last; s++) begin
        if (s != first)
          for (int g = 0; g < GAP; g++) begin
            exp_t e;
            e = idle_e(0, "R5"); e.ready = 0;
            exp_q.push_back(e);
          end
        for (int k = 0; k < STB; k++) begin
          exp_t e;
          e = idle_e(0, "R4"); e.cs_n = 0; e.wr_n = 0; e.ready = 0;
          if (s == 0) begin e.addr = 4'd1; e.dout = slot_of(ch); e.tag = "R2"; end
          else if (s == 1) begin e.addr = 4'd2; e.dout = rg; e.tag = "R3"; end
          else begin e.addr = 4'd0; e.dout = dt; e.tag = "R4"; end
          exp_q.push_back(e);
        end
      end
      @(posedge clk); #1;
      req_valid = 0;
      if (busy_n > 0) begin
        repeat (busy_n) @(posedge clk);
        #1;
      end
      bus_rdbit = 0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    vectors++;
    if (!(req_ready === 1 && bus_cs_n === 1 && bus_rd_n === 1 && bus_wr_n === 1 && req_err === 0))
      miss("R1", "reset state", {req_ready, bus_cs_n, bus_rd_n, bus_wr_n, req_err}, 5'b11110);
    checking = 1;

    // R4/R6: full write, no busy, then with busy hold-off
    do_req(2'b00, 0, 8'h12, 8'h34, 0);
    do_req(2'b00, 6, 8'hA5, 8'h5A, 3);
    // R2: every voice, group boundaries included
    for (int v = 0; v < 28; v++)
      do_req(2'b00, v, 8'(v * 3), 8'(~v), v % 4);
    // R7: slot-only form
    do_req(2'b01, 27, 8'hFF, 8'hFF, 1);
    // R7: register+data form ignores an out-of-range channel
    do_req(2'b10, 31, 8'h40, 8'hC3, 2);
    do_req(2'b10, 28, 8'h01, 8'h80, 0);
    // R7: op 2'b11 behaves as full
    do_req(2'b11, 14, 8'h77, 8'h66, 1);
    // R8: rejected channels
    do_req(2'b00, 28, 8'h11, 8'h22, 0);
    do_req(2'b01, 31, 8'h11, 8'h22, 0);
    do_req(2'b11, 29, 8'h11, 8'h22, 0);
    // R9/R10: back-to-back after a reject
    do_req(2'b00, 21, 8'h09, 8'h90, 0);
    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule